// File: doc/BRIEF.md
# Byte-Packing Four-Byte Data FIFO

This block is a small byte store that sits between a 16-bit processor data port and a byte-serial transfer engine. The processor loads outgoing data two bytes at a time. For a transfer with an odd number of bytes it loads the final byte alone. The engine drains those bytes one at a time, oldest first. In the other direction, the engine deposits incoming bytes one at a time, and the processor collects them as 16-bit words. A byte-order input selects which half of the 16-bit word holds the earlier byte, on both the write path and the read path.

The store holds one shared level count. Transmit bytes leave from the top of the occupied region. Receive bytes are appended just above the bytes already held, and reads take bytes from the bottom. Sticky status flags report five events: a read of an empty store, a pop of an empty store, a drain that ends with the store empty, a received byte being accepted, and a received byte being dropped.

Top module: `byte_pack_fifo`

## Requirements
- R1: The store never holds more than DEPTH (default 4) bytes, and `level_o` reports the byte count. After reset the level is 0, all flags are 0 and `eng_tx_byte_o` and `cpu_rdata_o` are 0.
- R2: A 16-bit write (`cpu_wr_i`=1, `cpu_wr_narrow_i`=0) appends two bytes and raises the level by 2. With `big_endian_i`=1, `cpu_wdata_i[15:8]` is sent before `cpu_wdata_i[7:0]`; with `big_endian_i`=0 the order is reversed. A write that would exceed DEPTH bytes is ignored.
- R3: A narrow write (`cpu_wr_narrow_i`=1) appends the single byte `cpu_wdata_i[7:0]` whatever `big_endian_i` is, and raises the level by 1. It is ignored when the store is full.
- R4: `eng_tx_byte_o` shows the oldest held transmit byte. `eng_tx_pop_i` on a non-empty store removes that byte and lowers the level by 1. A pop that takes the last byte sets `tx_rdy_o`.
- R5: A pop of an empty store leaves the level at 0 and sets `tx_udf_o`.
- R6: `eng_rx_push_i` places `eng_rx_byte_i` above the bytes already held, raises the level by 1 and sets `rx_rdy_o`. When the store is full the byte is dropped, the contents are unchanged and `rx_ovr_o` is set.
- R7: `cpu_rdata_o` shows the earliest received byte (byte 0) in bits 15:8 when `big_endian_i`=1 and in bits 7:0 when `big_endian_i`=0; the other half holds byte 1. When 2 or more bytes are held, a read consumes two bytes and moves the rest down. When 1 byte is held, the other half reads 0 and the read consumes one byte.
- R8: A read of an empty store returns 0, changes nothing and sets `empty_rd_o`.
- R9: Any processor write clears `tx_udf_o`, `tx_rdy_o` and `empty_rd_o`. Any read clears `rx_rdy_o` and `rx_ovr_o`. When a flag is set and cleared in the same cycle, the set wins.
- R10: When operations fall in the same cycle, the engine operation is applied first, then the read, then the write. The read returns the bytes held before the cycle and consumes at most as many bytes as were held before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | Byte order of the 16-bit data word |
| cpu_wr_i | input | 1 | Processor write strobe |
| cpu_wr_narrow_i | input | 1 | Write carries a single byte |
| cpu_wdata_i | input | 16 | Processor write data |
| cpu_rd_i | input | 1 | Processor read strobe |
| cpu_rdata_o | output | 16 | Data returned by a read in this cycle |
| eng_tx_pop_i | input | 1 | Engine takes one transmit byte |
| eng_tx_byte_o | output | 8 | Oldest held transmit byte |
| eng_rx_push_i | input | 1 | Engine delivers one receive byte |
| eng_rx_byte_i | input | 8 | Received byte |
| level_o | output | $clog2(DEPTH+1) | Bytes held |
| empty_rd_o | output | 1 | Read of an empty store occurred |
| tx_udf_o | output | 1 | Pop of an empty store occurred |
| tx_rdy_o | output | 1 | Store drained by the engine |
| rx_rdy_o | output | 1 | Received byte accepted |
| rx_ovr_o | output | 1 | Received byte dropped |

## Verification
The interesting collisions pair an engine operation with a processor operation on the same edge. One is a pop together with a 16-bit write. The other is a push together with a read. Each is provoked by raising both strobes in one cycle, starting from a level of 1 or 2. The bench then judges three things: the byte or word presented during that cycle, the level on the next cycle, and the order in which later pops or reads deliver the remaining bytes. It also raises a pop of an empty store together with a write, and checks that the underflow flag survives the clear that the write brings.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 16;
  localparam int CNT_W     = 2;

  localparam int FL_EMPTY_RD = 0;
  localparam int FL_TX_UDF   = 1;
  localparam int FL_TX_RDY   = 2;
  localparam int FL_RX_RDY   = 3;
  localparam int FL_RX_OVR   = 4;
  localparam int NUM_FLAGS   = 5;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/bpf_wr_pack.sv
module bpf_wr_pack
  import bpf_pkg::*;
(
  input  logic              big_endian_i,
  input  logic              narrow_i,
  input  word_t             wdata_i,
  output word_t             ins_word_o,
  output logic [CNT_W-1:0]  ins_cnt_o
);
  byte_t first_b, second_b;

  // first_b lands higher in the store and leaves first
  assign first_b  = big_endian_i ? wdata_i[15:8] : wdata_i[7:0];
  assign second_b = big_endian_i ? wdata_i[7:0]  : wdata_i[15:8];

  assign ins_word_o = narrow_i ? {8'h00, wdata_i[7:0]} : {first_b, second_b};
  assign ins_cnt_o  = narrow_i ? CNT_W'(1) : CNT_W'(2);
endmodule

// File: rtl/bpf_rd_unpack.sv
module bpf_rd_unpack
  import bpf_pkg::*;
(
  input  logic  big_endian_i,
  input  byte_t byte0_i,
  input  byte_t byte1_i,
  output word_t rdata_o
);
  assign rdata_o = big_endian_i ? {byte0_i, byte1_i} : {byte1_i, byte0_i};
endmodule

// File: rtl/bpf_store.sv
module bpf_store
  import bpf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_pop_i,
  input  logic             rx_push_i,
  input  byte_t            rx_byte_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  word_t            ins_word_i,
  input  logic [CNT_W-1:0] ins_cnt_i,
  output byte_t            byte0_o,
  output byte_t            byte1_o,
  output byte_t            tx_byte_o,
  output logic [LW-1:0]    lvl_o,
  output logic             ev_empty_rd_o,
  output logic             ev_udf_o,
  output logic             ev_last_tx_o,
  output logic             ev_rx_ok_o,
  output logic             ev_ovr_o
);
  localparam int DW = DEPTH * BYTE_W;
  localparam logic [DW-1:0] BYTE_MASK = DW'({BYTE_W{1'b1}});

  logic [DW-1:0] data_q, data_d, d_s1, d_s2;
  logic [LW-1:0] lvl_q, lvl_d, l_s1, l_s2, top_idx;
  int            take;

  assign top_idx   = (lvl_q == '0) ? '0 : lvl_q - 1'b1;
  assign tx_byte_o = data_q[int'(top_idx)*BYTE_W +: BYTE_W];
  assign byte0_o   = data_q[0 +: BYTE_W];
  assign byte1_o   = data_q[BYTE_W +: BYTE_W];
  assign lvl_o     = lvl_q;

  // engine op, then read, then write; bytes above the level stay zero
  always_comb begin
    ev_empty_rd_o = 1'b0;
    ev_udf_o      = 1'b0;
    ev_last_tx_o  = 1'b0;
    ev_rx_ok_o    = 1'b0;
    ev_ovr_o      = 1'b0;
    d_s1 = data_q;
    l_s1 = lvl_q;
    if (tx_pop_i) begin
      if (lvl_q == '0) begin
        ev_udf_o = 1'b1;
      end else begin
        d_s1 = data_q & ~(BYTE_MASK << (int'(top_idx) * BYTE_W));
        l_s1 = lvl_q - 1'b1;
        ev_last_tx_o = (lvl_q == LW'(1));
      end
    end
    if (rx_push_i) begin
      if (int'(l_s1) == DEPTH) begin
        ev_ovr_o = 1'b1;
      end else begin
        d_s1 = d_s1 | (DW'(rx_byte_i) << (int'(l_s1) * BYTE_W));
        l_s1 = l_s1 + 1'b1;
        ev_rx_ok_o = 1'b1;
      end
    end
    take = (int'(lvl_q) >= 2) ? 2 : int'(lvl_q);
    d_s2 = d_s1;
    l_s2 = l_s1;
    if (rd_i) begin
      if (lvl_q == '0) begin
        ev_empty_rd_o = 1'b1;
      end else begin
        d_s2 = d_s1 >> (take * BYTE_W);
        l_s2 = (int'(l_s1) > take) ? l_s1 - LW'(take) : '0;
      end
    end
    data_d = d_s2;
    lvl_d  = l_s2;
    if (wr_i && (int'(l_s2) + int'(ins_cnt_i) <= DEPTH)) begin
      data_d = (d_s2 << (int'(ins_cnt_i) * BYTE_W)) | DW'(ins_word_i);
      lvl_d  = l_s2 + LW'(ins_cnt_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      lvl_q  <= '0;
    end else begin
      data_q <= data_d;
      lvl_q  <= lvl_d;
    end
  end
endmodule

// File: rtl/bpf_flags.sv
module bpf_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/byte_pack_fifo.sv
module byte_pack_fifo
  import bpf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          big_endian_i,
  input  logic          cpu_wr_i,
  input  logic          cpu_wr_narrow_i,
  input  logic [15:0]   cpu_wdata_i,
  input  logic          cpu_rd_i,
  output logic [15:0]   cpu_rdata_o,
  input  logic          eng_tx_pop_i,
  output logic [7:0]    eng_tx_byte_o,
  input  logic          eng_rx_push_i,
  input  logic [7:0]    eng_rx_byte_i,
  output logic [LW-1:0] level_o,
  output logic          empty_rd_o,
  output logic          tx_udf_o,
  output logic          tx_rdy_o,
  output logic          rx_rdy_o,
  output logic          rx_ovr_o
);
  word_t            ins_word;
  logic [CNT_W-1:0] ins_cnt;
  byte_t            byte0, byte1;
  logic             ev_empty_rd, ev_udf, ev_last_tx, ev_rx_ok, ev_ovr;
  logic [NUM_FLAGS-1:0] fl_set, fl_clr, fl_q;

  bpf_wr_pack u_wr_pack (
    .big_endian_i (big_endian_i),
    .narrow_i     (cpu_wr_narrow_i),
    .wdata_i      (cpu_wdata_i),
    .ins_word_o   (ins_word),
    .ins_cnt_o    (ins_cnt)
  );

  bpf_store #(.DEPTH(DEPTH), .LW(LW)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_pop_i      (eng_tx_pop_i),
    .rx_push_i     (eng_rx_push_i),
    .rx_byte_i     (eng_rx_byte_i),
    .rd_i          (cpu_rd_i),
    .wr_i          (cpu_wr_i),
    .ins_word_i    (ins_word),
    .ins_cnt_i     (ins_cnt),
    .byte0_o       (byte0),
    .byte1_o       (byte1),
    .tx_byte_o     (eng_tx_byte_o),
    .lvl_o         (level_o),
    .ev_empty_rd_o (ev_empty_rd),
    .ev_udf_o      (ev_udf),
    .ev_last_tx_o  (ev_last_tx),
    .ev_rx_ok_o    (ev_rx_ok),
    .ev_ovr_o      (ev_ovr)
  );

  bpf_rd_unpack u_rd_unpack (
    .big_endian_i (big_endian_i),
    .byte0_i      (byte0),
    .byte1_i      (byte1),
    .rdata_o      (cpu_rdata_o)
  );

  always_comb begin
    fl_set = '0;
    fl_clr = '0;
    fl_set[FL_EMPTY_RD] = ev_empty_rd;
    fl_set[FL_TX_UDF]   = ev_udf;
    fl_set[FL_TX_RDY]   = ev_last_tx;
    fl_set[FL_RX_RDY]   = ev_rx_ok;
    fl_set[FL_RX_OVR]   = ev_ovr;
    fl_clr[FL_EMPTY_RD] = cpu_wr_i;
    fl_clr[FL_TX_UDF]   = cpu_wr_i;
    fl_clr[FL_TX_RDY]   = cpu_wr_i;
    fl_clr[FL_RX_RDY]   = cpu_rd_i;
    fl_clr[FL_RX_OVR]   = cpu_rd_i;
  end

  bpf_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fl_set),
    .clr_i  (fl_clr),
    .flag_o (fl_q)
  );

  assign empty_rd_o = fl_q[FL_EMPTY_RD];
  assign tx_udf_o   = fl_q[FL_TX_UDF];
  assign tx_rdy_o   = fl_q[FL_TX_RDY];
  assign rx_rdy_o   = fl_q[FL_RX_RDY];
  assign rx_ovr_o   = fl_q[FL_RX_OVR];
endmodule

// File: rtl/byte_pack_fifo_chk.sv
module byte_pack_fifo_chk #(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cpu_wr_i,
  input logic          cpu_wr_narrow_i,
  input logic          cpu_rd_i,
  input logic          eng_tx_pop_i,
  input logic          eng_rx_push_i,
  input logic [LW-1:0] level_o,
  input logic          empty_rd_o,
  input logic          tx_udf_o,
  input logic          tx_rdy_o,
  input logic          rx_rdy_o,
  input logic          rx_ovr_o
);
  logic only_pop, only_wr;
  assign only_pop = eng_tx_pop_i && !eng_rx_push_i && !cpu_rd_i && !cpu_wr_i;
  assign only_wr  = cpu_wr_i && !eng_tx_pop_i && !eng_rx_push_i && !cpu_rd_i;

  p_level_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level_o) <= DEPTH);

  p_full_wr_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_wr && !cpu_wr_narrow_i && int'(level_o) > DEPTH - 2 |=> $stable(level_o));

  p_pop_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_pop && level_o != '0 |=> level_o == $past(level_o) - 1'b1);

  p_empty_pop_udf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_tx_pop_i && level_o == '0 |=> tx_udf_o);

  p_full_push_ovr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rx_push_i && !eng_tx_pop_i && int'(level_o) == DEPTH |=> rx_ovr_o);

  p_empty_read_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i && level_o == '0 |=> empty_rd_o);

  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i && !eng_rx_push_i |=> !rx_rdy_o && !rx_ovr_o);

  p_write_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_wr_i && !eng_tx_pop_i && !(cpu_rd_i && level_o == '0)
    |=> !tx_udf_o && !tx_rdy_o && !empty_rd_o);
endmodule

bind byte_pack_fifo byte_pack_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cpu_wr_i        (cpu_wr_i),
  .cpu_wr_narrow_i (cpu_wr_narrow_i),
  .cpu_rd_i        (cpu_rd_i),
  .eng_tx_pop_i    (eng_tx_pop_i),
  .eng_rx_push_i   (eng_rx_push_i),
  .level_o         (level_o),
  .empty_rd_o      (empty_rd_o),
  .tx_udf_o        (tx_udf_o),
  .tx_rdy_o        (tx_rdy_o),
  .rx_rdy_o        (rx_rdy_o),
  .rx_ovr_o        (rx_ovr_o)
);

// File: tb/byte_pack_fifo_tb_top.sv
module byte_pack_fifo_tb_top;
  localparam int DEPTH = 4;
  localparam int LW    = $clog2(DEPTH + 1);

  localparam logic [2:0] OP_W16 = 3'd0, OP_W8 = 3'd1, OP_POP = 3'd2,
                         OP_PUSH = 3'd3, OP_RD = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic        be;
    logic [15:0] dat;
    logic [2:0]  lvl;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{OP_W16, 1'b1, 16'hA1B2, 3'd2, 16'h0000},
    '{OP_W16, 1'b0, 16'hC3D4, 3'd4, 16'h0000},
    '{OP_W16, 1'b0, 16'h1111, 3'd4, 16'h0000},
    '{OP_POP, 1'b0, 16'h0000, 3'd3, 16'h00A1},
    '{OP_POP, 1'b0, 16'h0000, 3'd2, 16'h00B2},
    '{OP_POP, 1'b0, 16'h0000, 3'd1, 16'h00D4},
    '{OP_POP, 1'b0, 16'h0000, 3'd0, 16'h00C3},
    '{OP_W8,  1'b0, 16'hEE55, 3'd1, 16'h0000},
    '{OP_POP, 1'b0, 16'h0000, 3'd0, 16'h0055},
    '{OP_PUSH,1'b0, 16'h0010, 3'd1, 16'h0000},
    '{OP_PUSH,1'b0, 16'h0020, 3'd2, 16'h0000},
    '{OP_PUSH,1'b0, 16'h0030, 3'd3, 16'h0000},
    '{OP_RD,  1'b1, 16'h0000, 3'd1, 16'h1020},
    '{OP_RD,  1'b0, 16'h0000, 3'd0, 16'h0030},
    '{OP_PUSH,1'b0, 16'h0040, 3'd1, 16'h0000},
    '{OP_PUSH,1'b0, 16'h0050, 3'd2, 16'h0000},
    '{OP_RD,  1'b0, 16'h0000, 3'd0, 16'h5040},
    '{OP_W16, 1'b1, 16'h0102, 3'd2, 16'h0000},
    '{OP_W8,  1'b1, 16'hFF03, 3'd3, 16'h0000},
    '{OP_W8,  1'b0, 16'h0004, 3'd4, 16'h0000},
    '{OP_W8,  1'b0, 16'h0005, 3'd4, 16'h0000},
    '{OP_POP, 1'b0, 16'h0000, 3'd3, 16'h0001},
    '{OP_POP, 1'b0, 16'h0000, 3'd2, 16'h0002},
    '{OP_POP, 1'b0, 16'h0000, 3'd1, 16'h0003},
    '{OP_POP, 1'b0, 16'h0000, 3'd0, 16'h0004}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic be, wr, wr_nar, rd, pop, push;
  logic [15:0] wdata;
  logic [7:0]  rxb;
  logic [15:0] rdata;
  logic [7:0]  txb;
  logic [LW-1:0] level;
  logic empty_rd, tx_udf, tx_rdy, rx_rdy, rx_ovr;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  byte_pack_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .big_endian_i (be),
    .cpu_wr_i (wr), .cpu_wr_narrow_i (wr_nar), .cpu_wdata_i (wdata),
    .cpu_rd_i (rd), .cpu_rdata_o (rdata),
    .eng_tx_pop_i (pop), .eng_tx_byte_o (txb),
    .eng_rx_push_i (push), .eng_rx_byte_i (rxb),
    .level_o (level), .empty_rd_o (empty_rd), .tx_udf_o (tx_udf),
    .tx_rdy_o (tx_rdy), .rx_rdy_o (rx_rdy), .rx_ovr_o (rx_ovr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr = 0; wr_nar = 0; rd = 0; pop = 0; push = 0; wdata = '0; rxb = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic string tag(input logic [2:0] op);
    case (op)
      OP_W16:  return "R2";
      OP_W8:   return "R3";
      OP_POP:  return "R4";
      OP_PUSH: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(); be = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 level", 16'(level), 16'h0);
    chk("R1 flags", {11'h0, empty_rd, tx_udf, tx_rdy, rx_rdy, rx_ovr}, 16'h0);
    chk("R1 outputs", {txb, rdata[7:0]} | {8'h0, rdata[15:8]}, 16'h0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      be = VEC[i].be;
      case (VEC[i].op)
        OP_W16:  begin wr = 1; wdata = VEC[i].dat; end
        OP_W8:   begin wr = 1; wr_nar = 1; wdata = VEC[i].dat; end
        OP_POP:  pop = 1;
        OP_PUSH: begin push = 1; rxb = VEC[i].dat[7:0]; end
        default: rd = 1;
      endcase
      #1;
      if (VEC[i].op == OP_POP) chk({tag(VEC[i].op), " tx byte"}, {8'h0, txb}, VEC[i].exp);
      if (VEC[i].op == OP_RD)  chk({tag(VEC[i].op), " rdata"}, rdata, VEC[i].exp);
      tick();
      chk({tag(VEC[i].op), " level"}, 16'(level), 16'(VEC[i].lvl));
    end
    chk("R4 last pop tx_rdy", {15'h0, tx_rdy}, 16'h1);

    // R5 pop of empty store
    pop = 1; tick();
    chk("R5 udf level", 16'(level), 16'h0);
    chk("R5 udf flag", {15'h0, tx_udf}, 16'h1);

    // R9 write clears transmit flags
    be = 1; wr = 1; wdata = 16'hAABB; tick();
    chk("R9 write clears udf/rdy", {14'h0, tx_udf, tx_rdy}, 16'h0);

    // R10 pop and write in one cycle
    be = 1; pop = 1; wr = 1; wdata = 16'hCCDD; #1;
    chk("R10 pop byte in collision", {8'h0, txb}, 16'h00AA);
    tick();
    chk("R10 level after pop+write", 16'(level), 16'h3);
    pop = 1; #1; chk("R10 order 1", {8'h0, txb}, 16'h00BB); tick();
    pop = 1; #1; chk("R10 order 2", {8'h0, txb}, 16'h00CC); tick();
    pop = 1; #1; chk("R10 order 3", {8'h0, txb}, 16'h00DD); tick();
    chk("R4 drained tx_rdy", {15'h0, tx_rdy}, 16'h1);

    // R9 set wins: empty pop with write
    be = 0; pop = 1; wr = 1; wdata = 16'h1234; tick();
    chk("R9 udf set wins", {14'h0, tx_udf, tx_rdy}, 16'h2);
    chk("R9 level after empty pop+write", 16'(level), 16'h2);
    pop = 1; #1; chk("R2 le first byte", {8'h0, txb}, 16'h0034); tick();
    pop = 1; #1; chk("R2 le second byte", {8'h0, txb}, 16'h0012); tick();

    // R8 empty read
    be = 1; rd = 1; #1;
    chk("R8 empty rdata", rdata, 16'h0);
    tick();
    chk("R8 empty flag", {15'h0, empty_rd}, 16'h1);
    chk("R8 level", 16'(level), 16'h0);
    wr = 1; wr_nar = 1; wdata = 16'h0009; tick();
    chk("R9 write clears empty_rd", {15'h0, empty_rd}, 16'h0);
    pop = 1; tick();

    // R6 overrun
    push = 1; rxb = 8'h11; tick();
    push = 1; rxb = 8'h22; tick();
    push = 1; rxb = 8'h33; tick();
    push = 1; rxb = 8'h44; tick();
    chk("R6 full level", 16'(level), 16'h4);
    chk("R6 rx_rdy", {15'h0, rx_rdy}, 16'h1);
    push = 1; rxb = 8'h55; tick();
    chk("R6 ovr flag", {15'h0, rx_ovr}, 16'h1);
    chk("R1 level capped", 16'(level), 16'h4);
    be = 0; rd = 1; #1;
    chk("R6 dropped byte kept out", rdata, 16'h2211);
    tick();
    chk("R9 read clears rx flags", {14'h0, rx_rdy, rx_ovr}, 16'h0);
    chk("R7 level after read", 16'(level), 16'h2);
    be = 1; rd = 1; #1;
    chk("R7 be word", rdata, 16'h3344);
    tick();
    chk("R7 level empty", 16'(level), 16'h0);

    // R10 read and push in one cycle
    push = 1; rxb = 8'h77; tick();
    be = 0; rd = 1; push = 1; rxb = 8'h88; #1;
    chk("R10 read sees pre-cycle byte", rdata, 16'h0077);
    tick();
    chk("R10 level after read+push", 16'(level), 16'h1);
    chk("R10 rx_rdy set wins", {15'h0, rx_rdy}, 16'h1);
    rd = 1; #1;
    chk("R10 pushed byte survives", rdata, 16'h0088);
    tick();
    chk("R10 final level", 16'(level), 16'h0);

    finish_run();
  end
endmodule